// File: doc/BRIEF.md
# Ring Oscillator Health Monitor

This block watches the sampled output of a group of free-running ring oscillators that feed an entropy source. For every oscillator it keeps a short history of sampled bits and looks for streams that are stuck or that repeat with a period of one to four samples. If such a repetition lasts long enough, the oscillator raises an alarm. The first alarm is only logged. A second alarm that arrives within a set number of samples shuts that oscillator down for good, until the next reset.

A population count of the shut-down oscillators is compared against a programmable limit and drives a sticky interrupt flag, cleared by a write-one pulse. The block also holds the software enable mask and produces the effective per-oscillator enable. That enable is the software bit, gated by the global run input and forced low for any oscillator that has been shut down.

Top module: `osc_health_mon`

## Requirements
- R1: On each strobe with its effective enable high, an oscillator compares the new sample with the samples 1, 2, 3 and 4 strobes back. This uses only history gathered since it was last enabled. Each lag has a run counter that increments on a match and clears on a mismatch. An alarm fires when any run reaches `alarm_thr`, after which all of that oscillator's runs restart from zero. A threshold of 0 never alarms. For example, with a threshold of 8, a constant stream alarms on its 9th sample and again on its 17th.
- R2: The first alarm of oscillator n sets bit n of `alarm_log`. The bit stays set until reset.
- R3: A second alarm on the same oscillator, within `WINDOW` strobes after an earlier alarm that opened a window, sets bit n of `shut_flags`. The bit stays set until reset.
- R4: If `WINDOW` strobes pass after an alarm with no further alarm, the pending state is dropped. The next alarm then only opens a new window.
- R5: While bit n of `shut_flags` is 1, `osc_en[n]` is 0, and a software write of 1 to that bit of the mask does not re-enable it.
- R6: The software mask resets to all ones. `osc_en` is the mask AND NOT `shut_flags` AND `run_en`, registered one cycle. It is all zeros while `run_en` is low.
- R7: While an oscillator's `osc_en` bit is 0, its samples are ignored and its history and runs are cleared.
- R8: `shut_cnt` equals the number of ones in `shut_flags`, one cycle later.
- R9: `ovf_irq` sets when `shut_cnt` becomes strictly greater than `shut_thr` (a count equal to the limit does not set it). It stays set until a cycle with `ovf_clr` high, and it does not set again while the count stays above the limit.
- R10: After reset, `alarm_log`, `shut_flags`, `shut_cnt` and `ovf_irq` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Global enable for all oscillators |
| smp_stb | input | 1 | One sample of every oscillator is valid this cycle |
| smp_bits | input | NUM_OSC | Sampled bit per oscillator |
| alarm_thr | input | THR_W | Run length that raises an alarm; 0 disables |
| shut_thr | input | SHT_W | Shutdown count limit for the overflow flag |
| sw_en_wr | input | 1 | Write strobe for the software enable mask |
| sw_en_data | input | NUM_OSC | New software enable mask |
| ovf_clr | input | 1 | Clears the overflow flag |
| alarm_log | output | NUM_OSC | Sticky per-oscillator first-alarm log |
| shut_flags | output | NUM_OSC | Sticky per-oscillator shutdown flags |
| osc_en | output | NUM_OSC | Effective per-oscillator enable |
| shut_cnt | output | CNT_W | Number of shut-down oscillators |
| ovf_irq | output | 1 | Shutdown overflow interrupt flag |

## Verification
The bench builds the block with four oscillators and a 16-strobe shutdown window, keeping the alarm threshold at 8. With these values a second alarm (8 strobes after the first) falls inside the window, and a 20-strobe quiet stretch lets the window expire, all within a short run. Four oscillators give enough room to reach a shutdown count equal to the limit and then one above it. A stream with period five is used as the well-behaved oscillator, because it matches no lag from 1 to 4 for long.

// File: rtl/osc_mon_pkg.sv
package osc_mon_pkg;
  // Number of lags checked by the repetition detector (periods 1..PATTERN_LAGS)
  localparam int unsigned PATTERN_LAGS = 4;
endpackage

// File: rtl/osc_pattern_det.sv
module osc_pattern_det
  import osc_mon_pkg::*;
#(
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             stb,
  input  logic             smp,
  input  logic [THR_W-1:0] thr,
  output logic             alarm
);
  localparam int LAGS   = PATTERN_LAGS;
  localparam int FILL_W = $clog2(LAGS + 1);

  logic [LAGS-1:0]             hist_q;
  logic [FILL_W-1:0]           fill_q;
  logic [LAGS-1:0][THR_W-1:0]  run_q, run_d;
  logic [LAGS-1:0]             hit;

  genvar p;
  generate
    for (p = 0; p < LAGS; p++) begin : g_lag
      logic same;
      assign same = (fill_q > FILL_W'(p)) && (smp == hist_q[p]);
      always_comb begin
        if (!same)                 run_d[p] = '0;
        else if (&run_q[p])        run_d[p] = run_q[p];
        else                       run_d[p] = run_q[p] + 1'b1;
      end
      assign hit[p] = same && (thr != '0) && (run_d[p] == thr);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      hist_q <= '0;
      fill_q <= '0;
      run_q  <= '0;
      alarm  <= 1'b0;
    end else begin
      alarm <= 1'b0;
      if (stb) begin
        hist_q <= {hist_q[LAGS-2:0], smp};
        if (fill_q != FILL_W'(LAGS)) fill_q <= fill_q + 1'b1;
        run_q  <= (|hit) ? '0 : run_d;
        alarm  <= |hit;
      end
    end
  end

  // R1
  alarm_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    alarm |-> $past(stb && active));
  // R1
  alarm_thr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    alarm |-> ($past(thr) != '0));
endmodule

// File: rtl/osc_alarm_track.sv
module osc_alarm_track #(
  parameter int WINDOW = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  logic alarm,
  output logic log_q,
  output logic shut_q
);
  localparam int WIN_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;

  logic             pend_q;
  logic [WIN_W-1:0] win_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      log_q  <= 1'b0;
      shut_q <= 1'b0;
      pend_q <= 1'b0;
      win_q  <= '0;
    end else if (alarm) begin
      log_q <= 1'b1;
      win_q <= '0;
      if (pend_q) begin
        shut_q <= 1'b1;
        pend_q <= 1'b0;
      end else begin
        pend_q <= 1'b1;
      end
    end else if (stb && pend_q) begin
      if (win_q == WIN_W'(WINDOW - 1)) pend_q <= 1'b0;
      else                             win_q  <= win_q + 1'b1;
    end
  end

  // R2
  shut_after_log_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(shut_q) |-> log_q);
  // R3
  shut_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    shut_q |=> shut_q);
  // R4
  pend_drop_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pend_q) |-> $past(alarm || stb));
endmodule

// File: rtl/osc_shut_count.sv
module osc_shut_count #(
  parameter int NUM_OSC = 24,
  parameter int CNT_W   = 6,
  parameter int SHT_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_OSC-1:0] flags,
  input  logic [SHT_W-1:0]   limit,
  input  logic               clr,
  output logic [CNT_W-1:0]   cnt_q,
  output logic               ovf_q
);
  logic [CNT_W-1:0] ones;
  logic             above, above_q;

  always_comb begin
    ones = '0;
    for (int i = 0; i < NUM_OSC; i++) ones = ones + CNT_W'(flags[i]);
  end

  assign above = cnt_q > CNT_W'(limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      above_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      cnt_q   <= ones;
      above_q <= above;
      if (above && !above_q) ovf_q <= 1'b1;
      else if (clr)          ovf_q <= 1'b0;
    end
  end

  // R8
  count_match_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cnt_q == CNT_W'($countones($past(flags))));
  // R9
  ovf_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_q) |-> ($past(cnt_q) > CNT_W'($past(limit))));
endmodule

// File: rtl/osc_health_mon.sv
module osc_health_mon #(
  parameter int NUM_OSC = 24,
  parameter int THR_W   = 8,
  parameter int SHT_W   = 5,
  parameter int CNT_W   = 6,
  parameter int WINDOW  = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run_en,
  input  logic               smp_stb,
  input  logic [NUM_OSC-1:0] smp_bits,
  input  logic [THR_W-1:0]   alarm_thr,
  input  logic [SHT_W-1:0]   shut_thr,
  input  logic               sw_en_wr,
  input  logic [NUM_OSC-1:0] sw_en_data,
  input  logic               ovf_clr,
  output logic [NUM_OSC-1:0] alarm_log,
  output logic [NUM_OSC-1:0] shut_flags,
  output logic [NUM_OSC-1:0] osc_en,
  output logic [CNT_W-1:0]   shut_cnt,
  output logic               ovf_irq
);
  logic [NUM_OSC-1:0] sw_q;
  logic [NUM_OSC-1:0] en_q;
  logic [NUM_OSC-1:0] alarm_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_q <= '1;
      en_q <= '0;
    end else begin
      sw_q <= (sw_en_wr ? sw_en_data : sw_q) & ~shut_flags;
      en_q <= sw_q & ~shut_flags & {NUM_OSC{run_en}};
    end
  end

  assign osc_en = en_q;

  genvar n;
  generate
    for (n = 0; n < NUM_OSC; n++) begin : g_osc
      osc_pattern_det #(.THR_W(THR_W)) u_det (
        .clk    (clk),
        .rst    (rst),
        .active (en_q[n]),
        .stb    (smp_stb),
        .smp    (smp_bits[n]),
        .thr    (alarm_thr),
        .alarm  (alarm_w[n])
      );
      osc_alarm_track #(.WINDOW(WINDOW)) u_trk (
        .clk    (clk),
        .rst    (rst),
        .stb    (smp_stb),
        .alarm  (alarm_w[n]),
        .log_q  (alarm_log[n]),
        .shut_q (shut_flags[n])
      );
    end
  endgenerate

  osc_shut_count #(.NUM_OSC(NUM_OSC), .CNT_W(CNT_W), .SHT_W(SHT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .flags (shut_flags),
    .limit (shut_thr),
    .clr   (ovf_clr),
    .cnt_q (shut_cnt),
    .ovf_q (ovf_irq)
  );

  // R5
  shut_forces_off_chk: assert property (@(posedge clk) disable iff (rst)
    (en_q & $past(shut_flags)) == '0);
  // R6
  run_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(run_en) |-> (en_q == '0));
endmodule

// File: tb/osc_health_mon_test.sv
module osc_health_mon_test;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         run_en = 1'b0;
  logic         smp_stb = 1'b0;
  logic [N-1:0] smp_bits = '0;
  logic [7:0]   alarm_thr = 8'd8;
  logic [4:0]   shut_thr = 5'd1;
  logic         sw_en_wr = 1'b0;
  logic [N-1:0] sw_en_data = '0;
  logic         ovf_clr = 1'b0;
  logic [N-1:0] alarm_log, shut_flags, osc_en;
  logic [5:0]   shut_cnt;
  logic         ovf_irq;

  always #5 clk = ~clk;

  osc_health_mon #(.NUM_OSC(N), .WINDOW(16)) uut (
    .clk(clk), .rst(rst), .run_en(run_en), .smp_stb(smp_stb), .smp_bits(smp_bits),
    .alarm_thr(alarm_thr), .shut_thr(shut_thr), .sw_en_wr(sw_en_wr),
    .sw_en_data(sw_en_data), .ovf_clr(ovf_clr), .alarm_log(alarm_log),
    .shut_flags(shut_flags), .osc_en(osc_en), .shut_cnt(shut_cnt), .ovf_irq(ovf_irq)
  );

  typedef struct {
    string        tag;
    logic [N-1:0] log;
    logic [N-1:0] shut;
    logic [N-1:0] en;
    logic [5:0]   cnt;
    logic         ovf;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  int   gk = 0;
  bit   done = 0;

  // kinds: 0 constant 0, 1 alternating, 2 period five (00011), 3 constant 1
  function automatic logic pat(input int kind, input int k);
    case (kind)
      0: return 1'b0;
      1: return k[0];
      2: return ((k % 5) >= 3);
      default: return 1'b1;
    endcase
  endfunction

  task automatic cmp(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected items and compares against the outputs
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      cmp(e.tag, "alarm_log",  8'(alarm_log),  8'(e.log));
      cmp(e.tag, "shut_flags", 8'(shut_flags), 8'(e.shut));
      cmp(e.tag, "osc_en",     8'(osc_en),     8'(e.en));
      cmp(e.tag, "shut_cnt",   8'(shut_cnt),   8'(e.cnt));
      cmp(e.tag, "ovf_irq",    8'(ovf_irq),    8'(e.ovf));
    end
  end

  task automatic expect_st(input string tag, input logic [N-1:0] lg, input logic [N-1:0] sh,
                           input logic [N-1:0] en, input logic [5:0] cnt, input logic ovf);
    exp_t e;
    e.tag = tag; e.log = lg; e.shut = sh; e.en = en; e.cnt = cnt; e.ovf = ovf;
    exp_q.push_back(e);
    @(posedge clk); #1;
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
    #1;
  endtask

  task automatic strobes(input int count, input int k0, input int k1, input int k2, input int k3);
    for (int s = 0; s < count; s++) begin
      @(posedge clk); #1;
      smp_bits = {pat(k3, gk), pat(k2, gk), pat(k1, gk), pat(k0, gk)};
      smp_stb = 1'b1;
      @(posedge clk); #1;
      smp_stb = 1'b0;
      gk++;
      settle();
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    settle();
    // R10 reset state, R6 enable low while run_en low
    expect_st("R10", 4'b0000, 4'b0000, 4'b0000, 6'd0, 1'b0);
    run_en = 1'b1;
    settle();
    expect_st("R6", 4'b0000, 4'b0000, 4'b1111, 6'd0, 1'b0);

    // R1: osc0 constant, others period five; 8 samples give 7 matches
    strobes(8, 0, 2, 2, 2);
    expect_st("R1 below", 4'b0000, 4'b0000, 4'b1111, 6'd0, 1'b0);
    strobes(1, 0, 2, 2, 2);
    expect_st("R2 first", 4'b0001, 4'b0000, 4'b1111, 6'd0, 1'b0);
    strobes(7, 0, 2, 2, 2);
    expect_st("R3 before", 4'b0001, 4'b0000, 4'b1111, 6'd0, 1'b0);
    strobes(1, 0, 2, 2, 2);
    // R3 shutdown; R9 count equal to limit does not set overflow
    expect_st("R3 shut", 4'b0001, 4'b0001, 4'b1110, 6'd1, 1'b0);

    // R4: single alarm on osc1, window expires, then another single alarm
    strobes(10, 0, 1, 2, 2);
    expect_st("R1 lag2", 4'b0011, 4'b0001, 4'b1110, 6'd1, 1'b0);
    strobes(20, 0, 2, 2, 2);
    strobes(10, 0, 1, 2, 2);
    expect_st("R4", 4'b0011, 4'b0001, 4'b1110, 6'd1, 1'b0);

    // R7: everything disabled by software, osc3 stuck is ignored
    @(posedge clk); #1;
    sw_en_data = 4'b0000; sw_en_wr = 1'b1;
    @(posedge clk); #1;
    sw_en_wr = 1'b0;
    settle();
    expect_st("R6 sw", 4'b0011, 4'b0001, 4'b0000, 6'd1, 1'b0);
    strobes(20, 0, 2, 2, 3);
    expect_st("R7", 4'b0011, 4'b0001, 4'b0000, 6'd1, 1'b0);

    // R5: writing ones cannot re-enable the shut oscillator
    @(posedge clk); #1;
    sw_en_data = 4'b1111; sw_en_wr = 1'b1;
    @(posedge clk); #1;
    sw_en_wr = 1'b0;
    settle();
    expect_st("R5", 4'b0011, 4'b0001, 4'b1110, 6'd1, 1'b0);

    // R9: second shutdown makes count 2 > limit 1
    strobes(17, 0, 2, 2, 3);
    expect_st("R9 set", 4'b1011, 4'b1001, 4'b0110, 6'd2, 1'b1);
    settle();
    expect_st("R9 hold", 4'b1011, 4'b1001, 4'b0110, 6'd2, 1'b1);
    @(posedge clk); #1;
    ovf_clr = 1'b1;
    @(posedge clk); #1;
    ovf_clr = 1'b0;
    settle();
    expect_st("R9 clr", 4'b1011, 4'b1001, 4'b0110, 6'd2, 1'b0);
    settle();
    expect_st("R8 keep", 4'b1011, 4'b1001, 4'b0110, 6'd2, 1'b0);

    // R6: global enable low turns all off, R2/R3 flags remain
    run_en = 1'b0;
    settle();
    expect_st("R6 off", 4'b1011, 4'b1001, 4'b0000, 6'd2, 1'b0);

    settle();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule